// File: doc/BRIEF.md
# SCSI Controller Command Sequencer

This block sits behind the register port of a SCSI bus controller. It watches byte writes into a small register window. When a byte lands in the command slot, the block decodes it. It then updates three result registers: the bus status, the interrupt cause and the sequence step. It also raises the interrupt line where the command calls for it. The top bit of the command byte selects DMA mode, and the stored command byte is visible at all times.

The two select commands do not finish at once. Each holds the sequencer busy for a fixed number of cycles, set by a parameter. At the end of that window it resolves the target. The target ID is taken from the bus-ID register at the moment the command is issued. It is then checked against a per-device presence vector. A command write that arrives during this window is thrown away and sets a sticky error flag. A read of the interrupt cause clears the interrupt flag in status and lowers the line. Data movement and the execution of a command on the target are handled elsewhere.

Top module: `scsi_cmd_seq`

## Requirements
- R1: After rst_n is released, status, interrupt cause, sequence step, stored command, irq, busy, await and error all read zero.
- R2: Every accepted write of byte B to address 3 stores B as the command, and dma_mode equals B[7]. An opcode (B[6:0]) outside the known set changes nothing else.
- R3: Opcode 0x01 (flush) sets interrupt cause 0x08 and sequence step 0.
- R4: Opcode 0x03 (bus reset) sets interrupt cause 0x80. It raises irq only when bit 6 of the configuration byte (address 8) is 0.
- R5: Opcode 0x02 (chip reset) clears status, interrupt cause, sequence step, irq, command, await, bus-ID and configuration, but not the error flag.
- R6: Opcodes 0x42/0x43 (select) make busy high for SEL_CYCLES cycles. The target is bus-ID (address 4) bits 2:0 as they stood at issue. If that device is absent, the result is status 0x80, cause 0x20, step 0, irq 1.
- R7: A 0x42 select of a present device ends with status 0x90, cause 0x18, step 4, irq 1.
- R8: A 0x43 select of a present device ends with status 0x92, cause 0x18, step 4, irq 1, and sets await. Opcode 0x10 (transfer) clears await, and in DMA mode it also clears status bit 4.
- R9: Opcode 0x11 (complete) in DMA mode sets status 0x93, cause 0x18, step 4. It raises irq in either mode. Without DMA it leaves the result registers unchanged.
- R10: Opcode 0x12 (message accepted) acts as R9, except that the cause becomes 0x20 and the step 0.
- R11: A pulse on intr_rd clears status bit 7 and irq, unless an event in the same cycle sets them again.
- R12: A command write while busy is dropped and sets cmd_err, which stays set until rst_n.
- R13: Opcodes 0x00, 0x1A and 0x44 change nothing but the stored command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register index (3 command, 4 bus-ID, 8 configuration) |
| wr_data | input | 8 | Write byte |
| intr_rd | input | 1 | Pulse: interrupt cause register is being read |
| dev_present | input | NDEV | One bit per target, 1 = device present |
| status_o | output | 8 | Status: bit 7 interrupt, bit 4 count done, bits 2:0 phase |
| intr_o | output | 8 | Interrupt cause |
| seq_o | output | 3 | Sequence step |
| irq_o | output | 1 | Interrupt line |
| cmd_o | output | 8 | Stored command byte |
| dma_mode_o | output | 1 | DMA mode of the stored command |
| busy_o | output | 1 | Select in progress |
| await_cmd_o | output | 1 | Stopped after select, waiting for command bytes |
| cmd_err_o | output | 1 | Sticky: a command was dropped while busy |

## Verification
The hardest case to reach is the busy window of a select. During it, a bus-ID rewrite must not retarget the command, and a colliding command write must be dropped. The stimulus issues a select and then, while busy is still high, rewrites the bus-ID register to an absent target and fires a flush into the command slot. The expected result is a successful select, an unchanged command byte, and a raised error flag. A bus reset paired with a same-cycle intr_rd checks that the new interrupt wins over the clear.

// File: rtl/scsi_seq_pkg.sv
package scsi_seq_pkg;

    typedef enum logic [3:0] {
        OP_NOP, OP_FLUSH, OP_CHIPRST, OP_BUSRST, OP_XFER, OP_CPLT,
        OP_MSGOK, OP_ATN, OP_SELA, OP_SELAS, OP_ENSEL, OP_UNK
    } op_e;

    localparam logic [7:0] ST_INT     = 8'h80;
    localparam logic [7:0] ST_CNTDONE = 8'h10;
    localparam logic [7:0] PH_CMD     = 8'h02;
    localparam logic [7:0] PH_STAT    = 8'h03;

    localparam logic [7:0] IR_FDONE   = 8'h08;
    localparam logic [7:0] IR_SVC     = 8'h10;
    localparam logic [7:0] IR_DISC    = 8'h20;
    localparam logic [7:0] IR_BRST    = 8'h80;

    localparam logic [2:0] STEP_IDLE  = 3'd0;
    localparam logic [2:0] STEP_DONE  = 3'd4;

    typedef struct packed {
        logic [7:0] status;
        logic [7:0] intr;
        logic [2:0] seq;
        logic       irq;
        logic [7:0] cmd;
        logic [7:0] busid;
        logic [7:0] cfg1;
        logic [2:0] tgt;
        logic       stop;
        logic       await_cmd;
        logic       err;
    } seq_state_t;

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
    import scsi_seq_pkg::*;
(
    input  logic [6:0] opcode,
    output op_e        op
);
    always_comb begin
        unique case (opcode)
            7'h00:   op = OP_NOP;
            7'h01:   op = OP_FLUSH;
            7'h02:   op = OP_CHIPRST;
            7'h03:   op = OP_BUSRST;
            7'h10:   op = OP_XFER;
            7'h11:   op = OP_CPLT;
            7'h12:   op = OP_MSGOK;
            7'h1A:   op = OP_ATN;
            7'h42:   op = OP_SELA;
            7'h43:   op = OP_SELAS;
            7'h44:   op = OP_ENSEL;
            default: op = OP_UNK;
        endcase
    end
endmodule

// File: rtl/scsi_sel_timer.sv
module scsi_sel_timer #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(CYCLES));

    // R6
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: rtl/scsi_cmd_seq.sv
module scsi_cmd_seq
    import scsi_seq_pkg::*;
#(
    parameter int NDEV       = 8,
    parameter int SEL_CYCLES = 3,
    parameter int CMD_ADDR   = 3,
    parameter int BUSID_ADDR = 4,
    parameter int CFG1_ADDR  = 8,
    parameter int QUIET_BIT  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [3:0]      wr_addr,
    input  logic [7:0]      wr_data,
    input  logic            intr_rd,
    input  logic [NDEV-1:0] dev_present,
    output logic [7:0]      status_o,
    output logic [7:0]      intr_o,
    output logic [2:0]      seq_o,
    output logic            irq_o,
    output logic [7:0]      cmd_o,
    output logic            dma_mode_o,
    output logic            busy_o,
    output logic            await_cmd_o,
    output logic            cmd_err_o
);
    localparam int TGT_W = (NDEV > 1) ? $clog2(NDEV) : 1;

    seq_state_t s_d, s_q;
    op_e        op;
    logic       busy, sel_done, sel_start, cmd_wr, accept, dma;

    scsi_cmd_decode u_dec (.opcode(wr_data[6:0]), .op(op));

    scsi_sel_timer #(.CYCLES(SEL_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(sel_start),
        .busy(busy), .done(sel_done)
    );

    assign cmd_wr = wr_en && (wr_addr == 4'(CMD_ADDR));
    assign accept = cmd_wr && !busy;
    assign dma    = wr_data[7];

    always_comb begin
        s_d       = s_q;
        sel_start = 1'b0;

        if (intr_rd) begin
            s_d.status[7] = 1'b0;
            s_d.irq       = 1'b0;
        end
        if (wr_en && wr_addr == 4'(BUSID_ADDR)) s_d.busid = wr_data;
        if (wr_en && wr_addr == 4'(CFG1_ADDR))  s_d.cfg1  = wr_data;
        if (cmd_wr && busy)                     s_d.err   = 1'b1;

        if (sel_done) begin
            s_d.irq = 1'b1;
            if (!dev_present[s_q.tgt[TGT_W-1:0]]) begin
                s_d.status = ST_INT;
                s_d.intr   = IR_DISC;
                s_d.seq    = STEP_IDLE;
            end else begin
                s_d.status    = s_q.stop ? (ST_INT | ST_CNTDONE | PH_CMD)
                                         : (ST_INT | ST_CNTDONE);
                s_d.intr      = IR_SVC | IR_FDONE;
                s_d.seq       = STEP_DONE;
                s_d.await_cmd = s_q.stop;
            end
        end

        if (accept) begin
            s_d.cmd = wr_data;
            unique case (op)
                OP_FLUSH: begin
                    s_d.intr = IR_FDONE;
                    s_d.seq  = STEP_IDLE;
                end
                OP_CHIPRST: begin
                    s_d     = '0;
                    s_d.err = s_q.err;
                end
                OP_BUSRST: begin
                    s_d.intr = IR_BRST;
                    if (!s_q.cfg1[QUIET_BIT]) s_d.irq = 1'b1;
                end
                OP_XFER: begin
                    if (dma) s_d.status[4] = 1'b0;
                    s_d.await_cmd = 1'b0;
                end
                OP_CPLT, OP_MSGOK: begin
                    if (dma) begin
                        s_d.status = ST_INT | ST_CNTDONE | PH_STAT;
                        s_d.intr   = IR_SVC | IR_FDONE;
                        s_d.seq    = STEP_DONE;
                    end
                    if (op == OP_MSGOK) begin
                        s_d.intr = IR_DISC;
                        s_d.seq  = STEP_IDLE;
                    end
                    s_d.irq = 1'b1;
                end
                OP_SELA, OP_SELAS: begin
                    sel_start = 1'b1;
                    s_d.tgt   = s_q.busid[2:0];
                    s_d.stop  = (op == OP_SELAS);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign status_o    = s_q.status;
    assign intr_o      = s_q.intr;
    assign seq_o       = s_q.seq;
    assign irq_o       = s_q.irq;
    assign cmd_o       = s_q.cmd;
    assign dma_mode_o  = s_q.cmd[7];
    assign busy_o      = busy;
    assign await_cmd_o = s_q.await_cmd;
    assign cmd_err_o   = s_q.err;

    // R12
    sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.err |=> s_q.err);

    // R12
    drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr) |=> ($stable(s_q.cmd) && s_q.err));

    // R4
    quiet_busrst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op == OP_BUSRST && s_q.cfg1[QUIET_BIT] && !s_q.irq) |=> !s_q.irq);

    // R11
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.irq) |-> ($past(intr_rd) || $past(accept && op == OP_CHIPRST)));

    // R7
    step_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.seq == STEP_IDLE) || (s_q.seq == STEP_DONE));
endmodule

// File: tb/sim_scsi_cmd_seq.sv
module sim_scsi_cmd_seq;
    localparam int SEL = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       intr_rd = 1'b0;
    logic [7:0] dev_present = 8'b0010_0000;
    logic [7:0] status_o, intr_o, cmd_o;
    logic [2:0] seq_o;
    logic       irq_o, dma_mode_o, busy_o, await_cmd_o, cmd_err_o;

    scsi_cmd_seq #(.SEL_CYCLES(SEL)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .intr_rd(intr_rd), .dev_present(dev_present),
        .status_o(status_o), .intr_o(intr_o), .seq_o(seq_o), .irq_o(irq_o),
        .cmd_o(cmd_o), .dma_mode_o(dma_mode_o), .busy_o(busy_o),
        .await_cmd_o(await_cmd_o), .cmd_err_o(cmd_err_o)
    );

    always #2.5 clk = ~clk;

    int vectors = 0, errors = 0, cycles = 0;
    string cur_req = "R1";
    bit checking = 1'b0;

    // behavioural reference state
    int m_status, m_intr, m_seq, m_irq, m_cmd, m_busid, m_cfg1;
    int m_tgt, m_stop, m_await, m_err, m_cnt;

    always @(posedge clk) begin
        int n_status, n_intr, n_seq, n_irq, n_cmd, n_busid, n_cfg1;
        int n_tgt, n_stop, n_await, n_err, n_cnt, op;
        bit d;
        if (!rst_n) begin
            m_status = 0; m_intr = 0; m_seq = 0; m_irq = 0; m_cmd = 0;
            m_busid = 0; m_cfg1 = 0; m_tgt = 0; m_stop = 0; m_await = 0;
            m_err = 0; m_cnt = 0;
        end else begin
            n_status = m_status; n_intr = m_intr; n_seq = m_seq; n_irq = m_irq;
            n_cmd = m_cmd; n_busid = m_busid; n_cfg1 = m_cfg1; n_tgt = m_tgt;
            n_stop = m_stop; n_await = m_await; n_err = m_err; n_cnt = m_cnt;
            if (intr_rd) begin n_status = n_status & 'h7F; n_irq = 0; end
            if (wr_en && wr_addr == 4) n_busid = wr_data;
            if (wr_en && wr_addr == 8) n_cfg1 = wr_data;
            if (m_cnt != 0) begin
                if (wr_en && wr_addr == 3) n_err = 1;
                n_cnt = m_cnt - 1;
                if (m_cnt == 1) begin
                    n_irq = 1;
                    if (!dev_present[m_tgt]) begin
                        n_status = 'h80; n_intr = 'h20; n_seq = 0;
                    end else begin
                        n_status = m_stop ? 'h92 : 'h90;
                        n_intr = 'h18; n_seq = 4;
                        n_await = m_stop;
                    end
                end
            end else if (wr_en && wr_addr == 3) begin
                n_cmd = wr_data; d = wr_data[7]; op = wr_data & 'h7F;
                case (op)
                    'h01: begin n_intr = 'h08; n_seq = 0; end
                    'h02: begin
                        n_status = 0; n_intr = 0; n_seq = 0; n_irq = 0; n_cmd = 0;
                        n_busid = 0; n_cfg1 = 0; n_tgt = 0; n_stop = 0; n_await = 0;
                    end
                    'h03: begin n_intr = 'h80; if (((m_cfg1 >> 6) & 1) == 0) n_irq = 1; end
                    'h10: begin if (d) n_status = n_status & ~'h10; n_await = 0; end
                    'h11, 'h12: begin
                        if (d) begin n_status = 'h93; n_intr = 'h18; n_seq = 4; end
                        if (op == 'h12) begin n_intr = 'h20; n_seq = 0; end
                        n_irq = 1;
                    end
                    'h42, 'h43: begin
                        n_cnt = SEL; n_tgt = m_busid % 8; n_stop = (op == 'h43);
                    end
                    default: ;
                endcase
            end
            m_status = n_status; m_intr = n_intr; m_seq = n_seq; m_irq = n_irq;
            m_cmd = n_cmd; m_busid = n_busid; m_cfg1 = n_cfg1; m_tgt = n_tgt;
            m_stop = n_stop; m_await = n_await; m_err = n_err; m_cnt = n_cnt;
        end
    end

    task automatic cmp(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (checking) begin
            cmp("status", status_o, m_status);
            cmp("intr", intr_o, m_intr);
            cmp("seq", seq_o, m_seq);
            cmp("irq", irq_o, m_irq);
            cmp("cmd", cmd_o, m_cmd);
            cmp("dma", dma_mode_o, (m_cmd >> 7) & 1);
            cmp("busy", busy_o, m_cnt != 0);
            cmp("await", await_cmd_o, m_await);
            cmp("err", cmd_err_o, m_err);
        end
        if (cycles > 20000) begin
            errors++;
            $display("FAIL %s watchdog actual=%0d expected=%0d", cur_req, cycles, 20000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_intr();
        intr_rd = 1'b1;
        @(negedge clk);
        intr_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        cmp("status", status_o, 0); cmp("irq", irq_o, 0);
        cmp("cmd", cmd_o, 0); cmp("busy", busy_o, 0);
        checking = 1'b1;

        cur_req = "R13"; wr(3, 8'h00); idle(1);
        cur_req = "R3";  wr(3, 8'h01); idle(1);
        cur_req = "R4";  wr(8, 8'h00); wr(3, 8'h03); idle(1);
        cur_req = "R11"; rd_intr(); idle(1);
        cur_req = "R4";  wr(8, 8'h40); wr(3, 8'h03); idle(1);
        cur_req = "R11"; wr(8, 8'h00);
        intr_rd = 1'b1; wr(3, 8'h83); intr_rd = 1'b0; idle(1);
        rd_intr();

        cur_req = "R7";  wr(4, 8'h05); wr(3, 8'h42);
        cur_req = "R12"; wr(3, 8'h01);
        cur_req = "R6";  wr(4, 8'h02); idle(SEL + 1);
        rd_intr();
        cur_req = "R6";  wr(3, 8'hC3); idle(SEL + 1);
        rd_intr();
        cur_req = "R8";  wr(4, 8'hF5); wr(3, 8'hC3); idle(SEL + 1);
        wr(3, 8'h90); idle(1);
        cur_req = "R9";  wr(3, 8'h91); idle(1); rd_intr();
        wr(3, 8'h11); idle(1); rd_intr();
        cur_req = "R10"; wr(3, 8'h92); idle(1); wr(3, 8'h12); idle(1);
        cur_req = "R2";  wr(3, 8'h7F); idle(1); wr(3, 8'hA5); idle(1);
        cur_req = "R13"; wr(3, 8'h1A); wr(3, 8'hC4); idle(1);
        cur_req = "R8";  wr(3, 8'h43); idle(SEL + 1); wr(3, 8'h10); idle(1);
        cur_req = "R5";  wr(4, 8'h07); wr(3, 8'h02); idle(2);
        cur_req = "R12"; idle(1);

        checking = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule